// File: doc/BRIEF.md
# Manchester Word Encoder with Sync

This block turns one 16-bit word per frame into a Manchester II line stream. Each frame is 40 half-bit periods long. It opens with a three-bit-time sync pattern, carries the 16 data bits most significant first, and closes with an odd-parity bit. The block runs from a single send clock at twice the bit rate, and every cycle of that clock is one half-bit on the line. It derives a bit-rate shift clock from the send clock and raises a send-data strobe that asks an external source for serial NRZ bits. It drives two active-low bipolar line controls: one pulls the line to its positive state and the other to its negative state.

Each frame chooses either a command sync or a data sync. If enable is still high when a frame ends, the next frame follows with no gap. An inhibit input parks the line without disturbing the sequencer. The synchronous reset also serves as the abort. Line drivers and the external data shift register sit outside this block.

Top module: `manch_word_encoder`

## Requirements
- R1: `shift_clk` is low while `rst_n` is low. After reset it toggles on every `clk` rising edge, so it runs at half the send-clock rate.
- R2: A frame starts at a rising `clk` edge where `shift_clk` was high (a falling shift edge) and `enc_en` was high, provided no frame is in progress. The frame lasts 40 `clk` cycles. Its first line half-bit appears in the second cycle after the start edge.
- R3: `sync_cmd` is sampled once per frame, at the rising shift edge that follows the start edge. The value 1 gives a command sync: three half-bits positive, then three half-bits negative. The value 0 gives the inverse, a data sync. Later changes to `sync_cmd` do not affect the frame.
- R4: Data bits go out most significant first, one per bit time. Each bit is `ser_in` sampled at a rising shift edge inside the send-data window. A 1 is sent as a positive half followed by a negative half; a 0 is sent as a negative half followed by a positive half.
- R5: `send_data` is high for exactly 32 `clk` cycles (16 shift periods) in each frame. It rises 6 cycles after the start edge.
- R6: After the data comes one parity bit, coded like a data bit, chosen so that the 16 data bits plus the parity bit contain an odd number of ones.
- R7: If `enc_en` is high at the edge that ends a frame's last half-bit, the next frame's sync follows in the very next cycle. If it is low, the line goes idle.
- R8: While `line_en` is low, `pos_n` and `neg_n` are both high in the same cycle. Frame timing and content carry on unchanged underneath.
- R9: `rst_n` low at a rising `clk` edge aborts any frame. From the next cycle both line outputs are high and `send_data` is low, and a fresh frame can start after `rst_n` returns high.
- R10: When no frame is active, both `pos_n` and `neg_n` are high. The positive line state is `pos_n` low; the negative line state is `neg_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Send clock, twice the bit rate; one cycle is one half-bit |
| rst_n | input | 1 | Synchronous active-low reset and transmission abort |
| enc_en | input | 1 | Start request, sampled at falling shift edges |
| sync_cmd | input | 1 | 1 selects a command sync, 0 selects a data sync |
| ser_in | input | 1 | Serial NRZ data from the external source |
| line_en | input | 1 | Active-high line enable; low forces both line outputs high |
| shift_clk | output | 1 | Bit-rate shift clock derived from `clk` |
| send_data | output | 1 | High while the encoder wants serial data |
| pos_n | output | 1 | Active-low drive for the positive line state |
| neg_n | output | 1 | Active-low drive for the negative line state |

## Verification
The assertions take for granted that `sync_cmd` is steady from the start edge through the following rising shift edge. They also assume that `ser_in` changes only away from rising shift edges and that `enc_en` is only meaningful at falling shift edges. The stimulus respects all three. It drives every input at the falling `clk` edge. It changes `sync_cmd` only after `send_data` has risen. It shifts `ser_in` one bit per shift period, in reply to `send_data` with `shift_clk` low. The abort holds `rst_n` low across two falling edges, so the serial driver and the reference model both see the reset.

// File: rtl/enc_pkg.sv
// Package: shared types and frame-geometry helpers for the Manchester encoder.
// Assumes a frame of sync halves per polarity, DATA_W bits and one parity bit.
package enc_pkg;

    // One half-bit symbol: whether the line is driven, and toward which state.
    typedef struct packed {
        logic act;   // 1: line driven, 0: idle
        logic lvl;   // 1: positive state, 0: negative state
    } sym_t;

    // Number of half-bit periods in one frame.
    function automatic int frame_halves(input int dw, input int sh);
        return 2 * sh + 2 * dw + 2;
    endfunction

    // Counter width that holds every half-bit index of a frame.
    function automatic int half_cw(input int dw, input int sh);
        return $clog2(frame_halves(dw, sh));
    endfunction

endpackage

// File: rtl/enc_seq_timer.sv
// Module: frame sequencer. Keeps the shift-clock phase, the busy flag and the
// half-bit index, and produces the send-data window.
// Assumes enc_en is meaningful only at falling shift edges (ph high before edge).
module enc_seq_timer #(
    parameter int DATA_W      = 16,
    parameter int SYNC_HALVES = 3,
    localparam int CW         = enc_pkg::half_cw(DATA_W, SYNC_HALVES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enc_en,
    output logic          ph,
    output logic          busy,
    output logic [CW-1:0] hcnt,
    output logic          send_data
);
    localparam int NH = enc_pkg::frame_halves(DATA_W, SYNC_HALVES);
    localparam logic [CW-1:0] LAST_H     = CW'(NH - 1);
    localparam logic [CW-1:0] DATA_FIRST = CW'(2 * SYNC_HALVES);
    localparam logic [CW-1:0] DATA_LAST  = CW'(2 * SYNC_HALVES + 2 * DATA_W - 1);

    // Shift-clock phase: toggles every send-clock cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) ph <= 1'b0;
        else        ph <= ~ph;
    end

    // Frame start, half-bit counting, and back-to-back or stop at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            hcnt <= '0;
        end else if (busy) begin
            if (hcnt == LAST_H) begin
                busy <= enc_en;
                hcnt <= '0;
            end else begin
                hcnt <= hcnt + 1'b1;
            end
        end else if (ph && enc_en) begin
            busy <= 1'b1;
            hcnt <= '0;
        end
    end

    // Data request window covering all data half-bits.
    always_comb send_data = busy && (hcnt >= DATA_FIRST) && (hcnt <= DATA_LAST);

    // R2
    start_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !ph);

    // R2
    half_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (ph == hcnt[0]));

    // R7
    stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && hcnt == LAST_H && !enc_en) |=> !busy);

    // R7
    back2back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && hcnt == LAST_H && enc_en) |=> (busy && hcnt == '0));
endmodule

// File: rtl/enc_symbol_gen.sv
// Module: symbol generator. Chooses the line level for the current half-bit
// from the latched sync type, the sampled data bit and the running parity.
// Assumes sync_cmd is steady at the edge ending half 0 and ser_in is steady at
// rising shift edges inside the data window.
module enc_symbol_gen #(
    parameter int DATA_W      = 16,
    parameter int SYNC_HALVES = 3,
    localparam int CW         = enc_pkg::half_cw(DATA_W, SYNC_HALVES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy,
    input  logic [CW-1:0] hcnt,
    input  logic          sync_cmd,
    input  logic          ser_in,
    output enc_pkg::sym_t sym_nxt
);
    localparam logic [CW-1:0] SYNC_END   = CW'(SYNC_HALVES);
    localparam logic [CW-1:0] DATA_FIRST = CW'(2 * SYNC_HALVES);
    localparam logic [CW-1:0] PAR_FIRST  = CW'(2 * SYNC_HALVES + 2 * DATA_W);

    logic sel_q, bit_q, par_q;
    logic sel_now, take;

    // Sync type in force this half: live input in half 0, latched afterwards.
    always_comb sel_now = (hcnt == '0) ? sync_cmd : sel_q;

    // Sampling point: first half of each data bit.
    always_comb take = busy && (hcnt >= DATA_FIRST) && (hcnt < PAR_FIRST) && !hcnt[0];

    // Latch sync type, hold the current data bit and accumulate parity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
            bit_q <= 1'b0;
            par_q <= 1'b0;
        end else if (busy && hcnt == '0) begin
            sel_q <= sync_cmd;
            par_q <= 1'b0;
        end else if (take) begin
            bit_q <= ser_in;
            par_q <= par_q ^ ser_in;
        end
    end

    // Level selection for the half-bit that ends at the coming edge.
    always_comb begin
        sym_nxt.act = busy;
        if (hcnt < SYNC_END)        sym_nxt.lvl = sel_now;
        else if (hcnt < DATA_FIRST) sym_nxt.lvl = ~sel_now;
        else if (hcnt < PAR_FIRST)  sym_nxt.lvl = hcnt[0] ? ~bit_q : ser_in;
        else                        sym_nxt.lvl = hcnt[0] ? par_q : ~par_q;
    end

    // R4
    mid_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && hcnt[0] && hcnt > DATA_FIRST) |-> (sym_nxt.lvl != $past(sym_nxt.lvl)));
endmodule

// File: rtl/enc_line_drv.sv
// Module: line output stage. Registers the symbol and converts it into two
// active-low bipolar controls, with an asynchronous-to-the-frame line enable.
// Assumes line_en is a level input; it gates only the pins, never the state.
module enc_line_drv (
    input  logic          clk,
    input  logic          rst_n,
    input  enc_pkg::sym_t sym_nxt,
    input  logic          line_en,
    output logic          pos_n,
    output logic          neg_n
);
    enc_pkg::sym_t sym_q;

    // Hold the symbol for one half-bit.
    always_ff @(posedge clk) begin
        if (!rst_n) sym_q <= '0;
        else        sym_q <= sym_nxt;
    end

    // Active-low drive of the positive and negative line states.
    always_comb begin
        pos_n = ~(sym_q.act &  sym_q.lvl & line_en);
        neg_n = ~(sym_q.act & ~sym_q.lvl & line_en);
    end
endmodule

// File: rtl/manch_word_encoder.sv
// Module: top of the Manchester word encoder. Joins the sequencer, the symbol
// generator and the line stage, and exposes the shift clock.
// Assumes one clk cycle per half-bit and a synchronous active-low reset.
module manch_word_encoder #(
    parameter int DATA_W      = 16,
    parameter int SYNC_HALVES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enc_en,
    input  logic sync_cmd,
    input  logic ser_in,
    input  logic line_en,
    output logic shift_clk,
    output logic send_data,
    output logic pos_n,
    output logic neg_n
);
    localparam int CW = enc_pkg::half_cw(DATA_W, SYNC_HALVES);

    logic          ph, busy;
    logic [CW-1:0] hcnt;
    enc_pkg::sym_t sym_nxt;

    enc_seq_timer #(.DATA_W(DATA_W), .SYNC_HALVES(SYNC_HALVES)) u_timer (
        .clk(clk), .rst_n(rst_n), .enc_en(enc_en),
        .ph(ph), .busy(busy), .hcnt(hcnt), .send_data(send_data)
    );

    enc_symbol_gen #(.DATA_W(DATA_W), .SYNC_HALVES(SYNC_HALVES)) u_symbol (
        .clk(clk), .rst_n(rst_n), .busy(busy), .hcnt(hcnt),
        .sync_cmd(sync_cmd), .ser_in(ser_in), .sym_nxt(sym_nxt)
    );

    enc_line_drv u_line (
        .clk(clk), .rst_n(rst_n), .sym_nxt(sym_nxt), .line_en(line_en),
        .pos_n(pos_n), .neg_n(neg_n)
    );

    // Shift clock follows the phase register directly.
    always_comb shift_clk = ph;

    // R10
    idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(busy) |-> (pos_n && neg_n));
endmodule

// File: tb/tb_manch_word_encoder.sv
`timescale 1ns/1ps
module tb_manch_word_encoder;
    logic clk = 1'b0;
    logic rst_n = 1'b0, enc_en = 1'b0, sync_cmd = 1'b0, ser_in = 1'b0, line_en = 1'b1;
    logic shift_clk, send_data, pos_n, neg_n;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 0, live = 0;

    // reference model state
    bit m_ph = 0, e_act = 0, e_lvl = 0, m_sd = 0;
    string e_tag = "R10";
    bit lq[$];
    string tq[$];
    logic [15:0] mq[$], dq[$];
    logic [15:0] cur = '0;
    int drv_k = 0;

    manch_word_encoder dut (
        .clk(clk), .rst_n(rst_n), .enc_en(enc_en), .sync_cmd(sync_cmd),
        .ser_in(ser_in), .line_en(line_en), .shift_clk(shift_clk),
        .send_data(send_data), .pos_n(pos_n), .neg_n(neg_n)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", tag, what, act, exp, cyc);
        end
    endtask

    // Build the 40 expected half-bit levels of one frame.
    task automatic build(input logic [15:0] w, input bit sel, input bit b2b);
        bit p;
        p = ($countones(w) % 2) == 0;
        for (int h = 0; h < 40; h++) begin
            if (h < 6) begin
                lq.push_back(h < 3 ? sel : !sel);
                tq.push_back(b2b ? "R7" : "R3");
            end else if (h < 38) begin
                bit b;
                b = w[15 - (h - 6) / 2];
                lq.push_back((h % 2 == 0) ? b : !b);
                tq.push_back("R4");
            end else begin
                lq.push_back(h == 38 ? p : !p);
                tq.push_back("R6");
            end
        end
    endtask

    // Reference model, advanced once per rising edge.
    always @(posedge clk) begin
        bit prev;
        cyc++;
        if (!rst_n) begin
            m_ph = 0; e_act = 0; lq.delete(); tq.delete();
        end else begin
            prev = m_ph;
            m_ph = !m_ph;
            if (lq.size() > 0) begin
                e_act = 1; e_lvl = lq.pop_front(); e_tag = tq.pop_front();
            end else begin
                e_act = 0;
            end
            if (lq.size() == 0 && prev && enc_en && mq.size() > 0)
                build(mq.pop_front(), sync_cmd, e_act);
        end
        m_sd = (lq.size() >= 3) && (lq.size() <= 34);
        live = 1;
    end

    // Serial data source: one bit per shift period while requested.
    always @(negedge clk) begin
        if (!rst_n) drv_k = 0;
        else if (send_data && !shift_clk) begin
            if (drv_k == 0 && dq.size() > 0) cur = dq.pop_front();
            ser_in = cur[15 - drv_k];
            drv_k = (drv_k + 1) % 16;
        end
    end

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        if (live && !done) begin
            bit ep, en;
            string tg;
            ep = !(e_act && e_lvl && line_en);
            en = !(e_act && !e_lvl && line_en);
            tg = !line_en ? "R8" : (e_act ? e_tag : "R10");
            if (e_act && line_en && pos_n && neg_n) tg = "R2";
            check(pos_n === ep, tg, "pos_n", pos_n, ep);
            check(neg_n === en, tg, "neg_n", neg_n, en);
            check(send_data === m_sd, "R5", "send_data", send_data, m_sd);
            check(shift_clk === m_ph, "R1", "shift_clk", shift_clk, m_ph);
        end
    end

    always @(posedge clk) begin
        if (cyc > 5000 && !done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL R2 watchdog: actual %0d expected %0d", cyc, 5000);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    task automatic wait_sd_rise();
        while (send_data) @(negedge clk);
        while (!send_data) @(negedge clk);
    endtask

    task automatic push_word(input logic [15:0] w);
        mq.push_back(w); dq.push_back(w);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 R10 reset state
        check(shift_clk === 1'b0, "R1", "reset shift_clk", shift_clk, 0);
        check(send_data === 1'b0, "R9", "reset send_data", send_data, 0);
        check(pos_n === 1'b1 && neg_n === 1'b1, "R10", "reset idle line", {pos_n, neg_n}, 3);
        rst_n = 1;
        repeat (4) @(negedge clk);

        // R3 command sync, R4/R6 data and parity
        push_word(16'hA5C3); sync_cmd = 1; enc_en = 1;
        wait_sd_rise(); enc_en = 0;
        repeat (50) @(negedge clk);

        // R3 data sync, sync_cmd changed mid-frame must not matter
        push_word(16'h0000); sync_cmd = 0; enc_en = 1;
        wait_sd_rise(); enc_en = 0; sync_cmd = 1;
        repeat (50) @(negedge clk);

        // R7 three frames back to back
        push_word(16'hFFFF); push_word(16'h8001); push_word(16'h7FFE);
        sync_cmd = 0; enc_en = 1;
        wait_sd_rise(); wait_sd_rise(); wait_sd_rise(); enc_en = 0;
        repeat (50) @(negedge clk);

        // R8 inhibit during data
        push_word(16'h1234); sync_cmd = 1; enc_en = 1;
        wait_sd_rise(); enc_en = 0;
        repeat (5) @(negedge clk);
        line_en = 0;
        repeat (10) @(negedge clk);
        line_en = 1;
        repeat (40) @(negedge clk);

        // R9 abort mid-frame, then a fresh frame
        push_word(16'hBEEF); sync_cmd = 0; enc_en = 1;
        wait_sd_rise(); repeat (8) @(negedge clk);
        enc_en = 0; rst_n = 0;
        @(negedge clk);
        check(pos_n === 1'b1 && neg_n === 1'b1, "R9", "abort idle line", {pos_n, neg_n}, 3);
        check(send_data === 1'b0, "R9", "abort send_data", send_data, 0);
        @(negedge clk);
        rst_n = 1;
        repeat (3) @(negedge clk);
        push_word(16'h0F0F); sync_cmd = 1; enc_en = 1;
        wait_sd_rise(); enc_en = 0;
        repeat (50) @(negedge clk);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule